// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Unit

This block resolves one instruction operand. The caller selects an addressing mode and supplies the instruction field, two register indices, the program counter and an element-size scale code. It then pulses `start`. The unit sequences zero, one or two dependent memory reads as the mode requires and returns the operand. For modes that reach memory it also returns the address the operand came from. When the operand is ready it raises `done` for one cycle.

The block holds a small register file. That register file supplies the base and index values, and the auto-update modes write their adjusted address back into it. A write port loads registers between operations. The memory side is a single read port. A request is held with a stable address until the memory answers with a valid pulse, after any number of cycles.

All address arithmetic wraps modulo 2^16. Offsets come from the low 8 bits of the instruction field, sign-extended. The scale code s selects an element size of 2^s, applied as a left shift.

Top module: `operand_fetch`

## Requirements
- R1: Mode code 0 (immediate) returns `field` as the operand, makes no memory request, leaves `eff_addr` at 0, and raises `done` in the cycle after `start` is taken.
- R2: Mode code 1 (register) returns register `ra_idx` as the operand, makes no memory request and raises `done` in the cycle after `start`.
- R3: Mode code 2 (direct) makes exactly one read, at `field`. It returns the read data, and `eff_addr` equals `field`.
- R4: Mode code 3 (memory indirect) makes exactly two reads. The first is at `field`. The second is at the data the first read returned. The operand is the second read's data, and `eff_addr` is that pointer.
- R5: Mode code 4 (register indirect) makes one read, at the value of register `ra_idx`.
- R6: Mode code 5 (base plus displacement) makes one read, at register `ra_idx` plus sign-extended `field[7:0]`, modulo 2^16.
- R7: Mode code 6 (indexed) makes one read, at register `ra_idx` plus register `rb_idx` shifted left by `scale` (element size 1, 2, 4 or 8 for codes 0 to 3), modulo 2^16.
- R8: Mode code 7 (PC-relative) makes one read, at `pc` plus sign-extended `field[7:0]`, modulo 2^16.
- R9: Mode code 8 (post-increment) reads at the old value of register `ra_idx`. Afterwards that register holds the old value plus 2^`scale`, modulo 2^16.
- R10: Mode code 9 (pre-decrement) reads at register `ra_idx` minus 2^`scale`, modulo 2^16. Afterwards that register holds that same address.
- R11: Mode codes 10 to 15 set `illegal`, return operand 0 and `eff_addr` 0, make no memory request, and raise `done` in the cycle after `start`. Any legal mode clears `illegal`.
- R12: `done` is high for one cycle per operation, and `busy` is low in that cycle. A `start` seen while `busy` is high is ignored. `mem_req` stays high with `mem_addr` unchanged until `mem_valid` is seen, however long the wait.
- R13: After reset, `busy`, `done`, `mem_req`, `illegal`, `operand` and `eff_addr` are 0, and every register reads 0.
- R14: A register write on `rf_we` is ignored in any cycle where `busy` or `start` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin resolving an operand; taken only while idle |
| mode | input | 4 | Addressing mode code |
| field | input | 16 | Immediate value, absolute address, or offset in bits 7:0 |
| ra_idx | input | 3 | Base or address register index |
| rb_idx | input | 3 | Index register index |
| pc | input | 16 | Current program counter |
| scale | input | 2 | Element size code, size = 2^scale |
| rf_we | input | 1 | Register write enable |
| rf_widx | input | 3 | Register write index |
| rf_wdata | input | 16 | Register write data |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: operand ready |
| operand | output | 16 | Resolved operand |
| eff_addr | output | 16 | Address the operand was read from, 0 for non-memory modes |
| illegal | output | 1 | Last operation had an unused mode code |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_valid | input | 1 | Read data valid pulse |
| mem_rdata | input | 16 | Read data |

## Verification
The memory model answers from a scrambling function of the address. A wrong read address therefore shows up as a wrong operand, and the logged read addresses tell the first read of an indirect fetch apart from the second. Directed cases aim at wrap-around: displacements that carry past 0xFFFF, negative offsets, the largest scale, incrementing from 0xFFFF and decrementing from 0. Random mode, register and offset mixes with response delays of 0 to 3 cycles show whether the address and update rules hold across modes. A 25-cycle stall tests the hold rule. A write and a second start, both issued mid-operation, show whether anything is accepted while busy.

// File: rtl/opf_pkg.sv
package opf_pkg;

   localparam int MODE_W = 4;

   typedef enum logic [MODE_W-1:0] {
      M_IMM     = 4'd0,
      M_REG     = 4'd1,
      M_DIR     = 4'd2,
      M_IND     = 4'd3,
      M_RIND    = 4'd4,
      M_BOFS    = 4'd5,
      M_IDX     = 4'd6,
      M_PCR     = 4'd7,
      M_POSTINC = 4'd8,
      M_PREDEC  = 4'd9
   } amode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_DEREF = 2'd2
   } fsm_e;

   function automatic logic mode_legal(input logic [MODE_W-1:0] m);
      return m <= 4'd9;
   endfunction

endpackage

// File: rtl/opf_regfile.sv
module opf_regfile #(
   parameter int W  = 16,
   parameter int N  = 8,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] rd_a_idx,
   output logic [W-1:0]  rd_a,
   input  logic [IW-1:0] rd_b_idx,
   output logic [W-1:0]  rd_b,
   input  logic          aw_en,
   input  logic [IW-1:0] aw_idx,
   input  logic [W-1:0]  aw_data,
   input  logic          xw_en,
   input  logic [IW-1:0] xw_idx,
   input  logic [W-1:0]  xw_data
);

   logic [W-1:0] regs [N];

   // the automatic update takes priority over the external port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) regs[i] <= '0;
      end else if (aw_en) begin
         regs[aw_idx] <= aw_data;
      end else if (xw_en) begin
         regs[xw_idx] <= xw_data;
      end
   end

   assign rd_a = regs[rd_a_idx];
   assign rd_b = regs[rd_b_idx];

endmodule

// File: rtl/opf_agen.sv
module opf_agen
   import opf_pkg::*;
#(
   parameter int AW        = 16,
   parameter int OFS_W     = 8,
   parameter int SC_W      = 2,
   parameter bit MUL_SCALE = 1'b0
) (
   input  logic [MODE_W-1:0] mode,
   input  logic [AW-1:0]     field,
   input  logic [AW-1:0]     ra_val,
   input  logic [AW-1:0]     rb_val,
   input  logic [AW-1:0]     pc,
   input  logic [SC_W-1:0]   scale,
   output logic [AW-1:0]     ea,
   output logic [AW-1:0]     upd_val
);

   logic [AW-1:0] disp;
   logic [AW-1:0] step;
   logic [AW-1:0] scaled;

   assign disp = {{(AW-OFS_W){field[OFS_W-1]}}, field[OFS_W-1:0]};
   assign step = {{(AW-1){1'b0}}, 1'b1} << scale;

   generate
      if (MUL_SCALE) begin : g_mul
         assign scaled = rb_val * step;
      end else begin : g_shift
         assign scaled = rb_val << scale;
      end
   endgenerate

   always_comb begin
      ea      = '0;
      upd_val = ra_val;
      case (amode_e'(mode))
         M_DIR, M_IND:  ea = field;
         M_RIND:        ea = ra_val;
         M_BOFS:        ea = ra_val + disp;
         M_IDX:         ea = ra_val + scaled;
         M_PCR:         ea = pc + disp;
         M_POSTINC: begin
            ea      = ra_val;
            upd_val = ra_val + step;
         end
         M_PREDEC: begin
            ea      = ra_val - step;
            upd_val = ra_val - step;
         end
         default:       ea = '0;
      endcase
   end

endmodule

// File: rtl/opf_seq.sv
module opf_seq
   import opf_pkg::*;
#(
   parameter int AW = 16,
   parameter int IW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [MODE_W-1:0] mode,
   input  logic [AW-1:0]     field,
   input  logic [IW-1:0]     ra_idx,
   input  logic [AW-1:0]     ra_val,
   input  logic [AW-1:0]     ea,
   input  logic [AW-1:0]     upd_val,
   input  logic              mem_valid,
   input  logic [AW-1:0]     mem_rdata,
   output logic              busy,
   output logic              done,
   output logic [AW-1:0]     operand,
   output logic [AW-1:0]     eff_addr,
   output logic              illegal,
   output logic              mem_req,
   output logic [AW-1:0]     mem_addr,
   output logic              auto_we,
   output logic [IW-1:0]     auto_idx,
   output logic [AW-1:0]     auto_data
);

   fsm_e          state;
   amode_e        cur_mode;
   logic [AW-1:0] upd_hold;
   logic [IW-1:0] idx_hold;
   logic          idle_start;
   logic          finish;

   assign busy       = (state != ST_IDLE);
   assign idle_start = (state == ST_IDLE) && start;
   assign finish     = mem_valid &&
                       ((state == ST_DEREF) ||
                        ((state == ST_FETCH) && (cur_mode != M_IND)));

   // pre-decrement writes back as the request is issued,
   // post-increment writes back when its data returns
   assign auto_we   = (idle_start && (mode == M_PREDEC)) ||
                      ((state == ST_FETCH) && mem_valid && (cur_mode == M_POSTINC));
   assign auto_idx  = (state == ST_IDLE) ? ra_idx  : idx_hold;
   assign auto_data = (state == ST_IDLE) ? upd_val : upd_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cur_mode <= M_IMM;
         upd_hold <= '0;
         idx_hold <= '0;
         done     <= 1'b0;
         operand  <= '0;
         eff_addr <= '0;
         illegal  <= 1'b0;
         mem_req  <= 1'b0;
         mem_addr <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  cur_mode <= amode_e'(mode);
                  upd_hold <= upd_val;
                  idx_hold <= ra_idx;
                  operand  <= '0;
                  eff_addr <= '0;
                  illegal  <= 1'b0;
                  if (!mode_legal(mode)) begin
                     illegal <= 1'b1;
                     done    <= 1'b1;
                  end else if (mode == M_IMM) begin
                     operand <= field;
                     done    <= 1'b1;
                  end else if (mode == M_REG) begin
                     operand <= ra_val;
                     done    <= 1'b1;
                  end else begin
                     mem_req  <= 1'b1;
                     mem_addr <= ea;
                     state    <= ST_FETCH;
                  end
               end
            end
            ST_FETCH: begin
               if (mem_valid && (cur_mode == M_IND)) begin
                  mem_addr <= mem_rdata;
                  state    <= ST_DEREF;
               end
            end
            ST_DEREF: ;
            default: state <= ST_IDLE;
         endcase
         if (finish) begin
            operand  <= mem_rdata;
            eff_addr <= mem_addr;
            done     <= 1'b1;
            mem_req  <= 1'b0;
            state    <= ST_IDLE;
         end
      end
   end

endmodule

// File: rtl/operand_fetch.sv
module operand_fetch
   import opf_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int OFS_W     = 8,
   parameter int REG_N     = 8,
   parameter int SC_W      = 2,
   parameter bit MUL_SCALE = 1'b0,
   localparam int RI_W     = $clog2(REG_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [MODE_W-1:0] mode,
   input  logic [DATA_W-1:0] field,
   input  logic [RI_W-1:0]   ra_idx,
   input  logic [RI_W-1:0]   rb_idx,
   input  logic [DATA_W-1:0] pc,
   input  logic [SC_W-1:0]   scale,
   input  logic              rf_we,
   input  logic [RI_W-1:0]   rf_widx,
   input  logic [DATA_W-1:0] rf_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] operand,
   output logic [DATA_W-1:0] eff_addr,
   output logic              illegal,
   output logic              mem_req,
   output logic [DATA_W-1:0] mem_addr,
   input  logic              mem_valid,
   input  logic [DATA_W-1:0] mem_rdata
);

   generate
      if (OFS_W < 2 || OFS_W > DATA_W) begin : g_bad_ofs
         $error("operand_fetch: OFS_W must lie in 2..DATA_W");
      end
      if (REG_N < 2 || (REG_N & (REG_N - 1)) != 0) begin : g_bad_regn
         $error("operand_fetch: REG_N must be a power of two, at least 2");
      end
      if (SC_W < 1 || SC_W > 3) begin : g_bad_sc
         $error("operand_fetch: SC_W must lie in 1..3");
      end
   endgenerate

   logic [DATA_W-1:0] ra_val, rb_val;
   logic [DATA_W-1:0] ea, upd_val;
   logic              auto_we;
   logic [RI_W-1:0]   auto_idx;
   logic [DATA_W-1:0] auto_data;
   logic              ext_we;

   assign ext_we = rf_we && !busy && !start;

   opf_regfile #(.W(DATA_W), .N(REG_N)) u_rf (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_a_idx (ra_idx),
      .rd_a     (ra_val),
      .rd_b_idx (rb_idx),
      .rd_b     (rb_val),
      .aw_en    (auto_we),
      .aw_idx   (auto_idx),
      .aw_data  (auto_data),
      .xw_en    (ext_we),
      .xw_idx   (rf_widx),
      .xw_data  (rf_wdata)
   );

   opf_agen #(.AW(DATA_W), .OFS_W(OFS_W), .SC_W(SC_W), .MUL_SCALE(MUL_SCALE)) u_agen (
      .mode    (mode),
      .field   (field),
      .ra_val  (ra_val),
      .rb_val  (rb_val),
      .pc      (pc),
      .scale   (scale),
      .ea      (ea),
      .upd_val (upd_val)
   );

   opf_seq #(.AW(DATA_W), .IW(RI_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mode      (mode),
      .field     (field),
      .ra_idx    (ra_idx),
      .ra_val    (ra_val),
      .ea        (ea),
      .upd_val   (upd_val),
      .mem_valid (mem_valid),
      .mem_rdata (mem_rdata),
      .busy      (busy),
      .done      (done),
      .operand   (operand),
      .eff_addr  (eff_addr),
      .illegal   (illegal),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .auto_we   (auto_we),
      .auto_idx  (auto_idx),
      .auto_data (auto_data)
   );

endmodule

// File: rtl/opf_checker.sv
module opf_checker #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [3:0]    mode,
   input logic          busy,
   input logic          done,
   input logic [AW-1:0] operand,
   input logic          illegal,
   input logic          mem_req,
   input logic [AW-1:0] mem_addr,
   input logic          mem_valid
);

   logic [3:0] cap_mode;
   logic [1:0] beats;
   logic [1:0] want_beats;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_mode <= '0;
         beats    <= '0;
      end else if (start && !busy) begin
         cap_mode <= mode;
         beats    <= '0;
      end else if (done) begin
         beats <= '0;
      end else if (mem_req && mem_valid && beats != 2'd3) begin
         beats <= beats + 2'd1;
      end
   end

   always_comb begin
      if (cap_mode <= 4'd1 || cap_mode > 4'd9) want_beats = 2'd0;
      else if (cap_mode == 4'd3)               want_beats = 2'd2;
      else                                     want_beats = 2'd1;
   end

   // read count per mode: none for R1/R2/R11, two for R4, one otherwise
   assert_beats_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> beats == want_beats);

   assert_hold_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> !done);

   assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_idle_noreq_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   assert_illegal_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done && illegal |-> operand == '0);

endmodule

bind operand_fetch opf_checker #(.AW(DATA_W)) u_opf_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .mode      (mode),
   .busy      (busy),
   .done      (done),
   .operand   (operand),
   .illegal   (illegal),
   .mem_req   (mem_req),
   .mem_addr  (mem_addr),
   .mem_valid (mem_valid)
);

// File: tb/tb_operand_fetch.sv
`timescale 1ns/1ps
module tb_operand_fetch;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  mode = '0;
   logic [15:0] field = '0;
   logic [2:0]  ra_idx = '0, rb_idx = '0;
   logic [15:0] pc = '0;
   logic [1:0]  scale = '0;
   logic        rf_we = 1'b0;
   logic [2:0]  rf_widx = '0;
   logic [15:0] rf_wdata = '0;
   logic        busy, done, illegal, mem_req;
   logic [15:0] operand, eff_addr, mem_addr;
   logic        mem_valid = 1'b0;
   logic [15:0] mem_rdata = '0;

   int errors = 0;
   int checks = 0;
   int dly_lo = 0, dly_hi = 3;
   int rd_cnt = 0;
   logic [15:0] rd_log [4];
   logic [15:0] model [8];
   logic [15:0] got_op;

   always #10 clk = ~clk;

   operand_fetch dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .field(field),
      .ra_idx(ra_idx), .rb_idx(rb_idx), .pc(pc), .scale(scale),
      .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
      .busy(busy), .done(done), .operand(operand), .eff_addr(eff_addr),
      .illegal(illegal), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_valid(mem_valid), .mem_rdata(mem_rdata)
   );

   function automatic logic [15:0] memf(input logic [15:0] a);
      logic [15:0] t;
      t = a ^ 16'h3C5A;
      return t * 16'd5 + 16'd17;
   endfunction

   function automatic logic [15:0] sx8(input logic [15:0] f);
      return {{8{f[7]}}, f[7:0]};
   endfunction

   function automatic string tag_of(input logic [3:0] m);
      case (m)
         4'd0: return "R1";
         4'd1: return "R2";
         4'd2: return "R3";
         4'd3: return "R4";
         4'd4: return "R5";
         4'd5: return "R6";
         4'd6: return "R7";
         4'd7: return "R8";
         4'd8: return "R9";
         4'd9: return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   // memory responder: answers each request after a random delay
   initial begin
      bit pending = 0;
      int dly = 0;
      forever begin
         @(negedge clk);
         mem_valid = 1'b0;
         if (mem_req && !pending) begin
            pending = 1;
            dly = $urandom_range(dly_hi, dly_lo);
         end
         if (pending) begin
            if (dly == 0) begin
               mem_valid = 1'b1;
               mem_rdata = memf(mem_addr);
               if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr;
               rd_cnt++;
               pending = 0;
            end else begin
               dly--;
            end
         end
      end
   end

   task automatic wr_reg(input logic [2:0] i, input logic [15:0] v);
      @(negedge clk);
      rf_we = 1'b1; rf_widx = i; rf_wdata = v;
      @(negedge clk);
      rf_we = 1'b0;
      model[i] = v;
   endtask

   task automatic do_op(input logic [3:0] m, input logic [15:0] f,
                        input logic [2:0] a, input logic [2:0] b,
                        input logic [15:0] p, input logic [1:0] sc,
                        input bit poke);
      logic [15:0] step, e_op, e_ea, e_a1, e_a2, ptr;
      int e_rd;
      bit e_ill;
      int n;
      string t;
      t = tag_of(m);
      step = 16'd1 << sc;
      e_rd = 1; e_ill = 0; e_a1 = '0; e_a2 = '0; e_ea = '0; e_op = '0;
      case (m)
         4'd0: begin e_rd = 0; e_op = f; end
         4'd1: begin e_rd = 0; e_op = model[a]; end
         4'd2: e_a1 = f;
         4'd3: begin ptr = memf(f); e_rd = 2; e_a1 = f; e_a2 = ptr; end
         4'd4: e_a1 = model[a];
         4'd5: e_a1 = model[a] + sx8(f);
         4'd6: e_a1 = model[a] + (model[b] << sc);
         4'd7: e_a1 = p + sx8(f);
         4'd8: e_a1 = model[a];
         4'd9: e_a1 = model[a] - step;
         default: begin e_rd = 0; e_ill = 1; end
      endcase
      if (e_rd == 1) begin e_ea = e_a1; e_op = memf(e_a1); end
      if (e_rd == 2) begin e_ea = e_a2; e_op = memf(e_a2); end
      rd_cnt = 0;
      @(negedge clk);
      mode = m; field = f; ra_idx = a; rb_idx = b; pc = p; scale = sc;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         // R14 / R12: write and a second start while busy
         rf_we = 1'b1; rf_widx = a; rf_wdata = ~model[a];
         start = 1'b1; mode = 4'd0;
      end
      n = 0;
      while (!done && n < 400) begin
         @(negedge clk);
         rf_we = 1'b0; start = 1'b0;
         n++;
      end
      rf_we = 1'b0; start = 1'b0;
      checks++;
      if (!done) begin
         errors++;
         $display("FAIL R12 no done: got 0 expected 1 (mode %0d)", m);
         return;
      end
      got_op = operand;
      chk(t, "operand", operand, e_op);
      chk(t, "eff_addr", eff_addr, e_ea);
      chk(t, "illegal", {15'd0, illegal}, {15'd0, e_ill});
      chk(t, "busy at done", {15'd0, busy}, 16'd0);
      if (e_rd >= 1) chk(t, "first read addr", rd_log[0], e_a1);
      if (e_rd == 2) chk(t, "second read addr", rd_log[1], e_a2);
      if (m == 4'd8) model[a] = model[a] + step;
      if (m == 4'd9) model[a] = model[a] - step;
      @(negedge clk);
      chk("R12", "done pulse width", {15'd0, done}, 16'd0);
      if (poke) begin
         repeat (3) begin
            @(negedge clk);
            chk("R12", "start while busy gave done", {15'd0, done}, 16'd0);
         end
      end
      chk(t, "read count", 16'(rd_cnt), 16'(e_rd));
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd24601));
      for (int i = 0; i < 8; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13 reset state
      chk("R13", "busy", {15'd0, busy}, 16'd0);
      chk("R13", "done", {15'd0, done}, 16'd0);
      chk("R13", "mem_req", {15'd0, mem_req}, 16'd0);
      chk("R13", "illegal", {15'd0, illegal}, 16'd0);
      chk("R13", "operand", operand, 16'd0);
      chk("R13", "eff_addr", eff_addr, 16'd0);
      do_op(4'd1, 16'h0, 3'd5, 3'd0, 16'h0, 2'd0, 0);
      chk("R13", "register after reset", got_op, 16'd0);

      // directed corner cases
      do_op(4'd0, 16'hBEEF, 3'd0, 3'd0, 16'h0, 2'd0, 0);
      wr_reg(3'd1, 16'hFFF0);
      wr_reg(3'd2, 16'h4000);
      wr_reg(3'd3, 16'h1FFF);
      do_op(4'd1, 16'h0, 3'd1, 3'd0, 16'h0, 2'd0, 0);
      do_op(4'd2, 16'h1234, 3'd0, 3'd0, 16'h0, 2'd0, 0);
      do_op(4'd3, 16'h0042, 3'd0, 3'd0, 16'h0, 2'd0, 0);
      do_op(4'd4, 16'h0, 3'd2, 3'd0, 16'h0, 2'd0, 0);
      do_op(4'd5, 16'h0020, 3'd1, 3'd0, 16'h0, 2'd0, 0);  // wraps to 0x0010
      do_op(4'd5, 16'h0080, 3'd2, 3'd0, 16'h0, 2'd0, 0);  // -128
      do_op(4'd6, 16'h0, 3'd2, 3'd3, 16'h0, 2'd3, 0);     // large scaled index wraps
      do_op(4'd7, 16'h00F8, 3'd0, 3'd0, 16'h0005, 2'd0, 0); // 5 - 8 = 0xFFFD
      wr_reg(3'd4, 16'hFFFF);
      do_op(4'd8, 16'h0, 3'd4, 3'd0, 16'h0, 2'd0, 0);
      do_op(4'd1, 16'h0, 3'd4, 3'd0, 16'h0, 2'd0, 0);
      chk("R9", "post-increment wrap", got_op, 16'h0000);
      do_op(4'd9, 16'h0, 3'd5, 3'd0, 16'h0, 2'd2, 0);
      do_op(4'd1, 16'h0, 3'd5, 3'd0, 16'h0, 2'd0, 0);
      chk("R10", "pre-decrement wrap", got_op, 16'hFFFC);
      do_op(4'd15, 16'hFFFF, 3'd0, 3'd0, 16'h0, 2'd0, 0);
      do_op(4'd10, 16'h1111, 3'd0, 3'd0, 16'h0, 2'd0, 0);
      do_op(4'd0, 16'h0001, 3'd0, 3'd0, 16'h0, 2'd0, 0);
      chk("R11", "illegal cleared by legal mode", {15'd0, illegal}, 16'd0);

      // write and start while busy
      wr_reg(3'd6, 16'h1234);
      dly_lo = 2; dly_hi = 2;
      do_op(4'd4, 16'h0, 3'd6, 3'd0, 16'h0, 2'd0, 1);
      do_op(4'd1, 16'h0, 3'd6, 3'd0, 16'h0, 2'd0, 0);
      chk("R14", "write while busy ignored", got_op, 16'h1234);

      // long stall
      dly_lo = 25; dly_hi = 25;
      do_op(4'd3, 16'h7777, 3'd0, 3'd0, 16'h0, 2'd0, 0);
      dly_lo = 0; dly_hi = 3;

      // constrained random mix
      for (int k = 0; k < 200; k++) begin
         logic [3:0] m;
         if ($urandom_range(0, 4) == 0)
            wr_reg(3'($urandom_range(0, 7)), 16'($urandom()));
         if ($urandom_range(0, 9) == 0) m = 4'($urandom_range(10, 15));
         else                           m = 4'($urandom_range(0, 9));
         do_op(m, 16'($urandom()), 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
               16'($urandom()), 2'($urandom_range(0, 3)), 0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule